// File: doc/BRIEF.md
# UART Modem Status Register

This block implements the modem status register of a 16550-compatible serial port. Four active-low modem inputs come in: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input is brought into the clock domain through a chain of synchronizing flops. The register reports the current, active-high state of each line. Next to those states it keeps four sticky change flags, each recording that its line moved since the register was last read. A single read strobe marks the read. The read data stays valid on the output at all times, and the strobe clears every change flag on the following clock edge.

In loopback mode the four outputs of the modem control register take the place of the external lines. Data-terminal-ready feeds data-set-ready, request-to-send feeds clear-to-send, and the two user outputs feed the ring and carrier inputs. The external pins have no effect in this mode. The last-sample register that drives change detection resets to the idle (high) level. As a result, a line that is still asserted when reset is released raises its change flag. An interrupt request is active while any change flag is set, provided the modem-status interrupt enable is high.

Top module: `uart_msr`

## Requirements
- R1: Read data bits 7..4 give the active-high state of carrier detect (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). An external pin change reaches these bits after two clock edges.
- R2: The change flags for clear-to-send (bit 0), data-set-ready (bit 1) and carrier detect (bit 3) set on either direction of level change. Each stays set until a read.
- R3: The ring change flag (bit 2) sets only when the ring line returns from low (asserted) to high (idle). A fall of the ring line leaves the flag unchanged.
- R4: A cycle with the read strobe high clears all four change flags at the next clock edge, unless a line changes in that same cycle.
- R5: When a read and a new line change fall in the same cycle, the flag of the changed line is set after the edge.
- R6: While reset is low and loopback is off, the read data is 0x00. A line held asserted across reset release sets its change flag once its synchronized value arrives.
- R7: With loopback on, bits 7..4 equal OUT2, OUT1, DTR and RTS. The external modem pins have no effect on any bit in this mode.
- R8: With loopback on, the change flags follow changes of the control bits that stand in for each line. The ring flag sets when OUT1 goes from 1 to 0.
- R9: The interrupt output is high exactly when the enable input is high and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| loop_en | input | 1 | Loopback mode select |
| mcr_dtr | input | 1 | Modem control DTR bit |
| mcr_rts | input | 1 | Modem control RTS bit |
| mcr_out1 | input | 1 | Modem control user output 1 |
| mcr_out2 | input | 1 | Modem control user output 2 |
| rd_en | input | 1 | Status register read strobe, one cycle per read |
| msi_en | input | 1 | Modem-status interrupt enable |
| rdata | output | 8 | Status register contents |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The properties assume three things about the inputs. The read strobe and the enable are synchronous to the clock. The control bits and the loopback select change only between edges. The external pins may be asynchronous, because they are sampled only through the synchronizer. The bench drives every input on the falling edge. It changes the loopback select and the control bits together with the pins in the same half cycle, and it samples outputs on the falling edge after the last register in each path has loaded. Every line change is given a full settling window before the next read, except where the bench deliberately lines up a read with the edge that records a change.

// File: rtl/uart_msr_pkg.sv
package uart_msr_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned IDX_CTS   = 0;
  localparam int unsigned IDX_DSR   = 1;
  localparam int unsigned IDX_RI    = 2;
  localparam int unsigned IDX_DCD   = 3;
  localparam int unsigned RDATA_W   = 2 * NUM_LINES;

  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_nx;

  always_comb begin
    stg_nx[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      stg_nx[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_nx;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
  import uart_msr_pkg::*;
(
  input  logic      loop_en,
  input  line_vec_t ext_n,
  input  logic      mcr_dtr,
  input  logic      mcr_rts,
  input  logic      mcr_out1,
  input  logic      mcr_out2,
  output line_vec_t line_n
);
  line_vec_t loop_n;

  always_comb begin
    loop_n          = '1;
    loop_n[IDX_CTS] = ~mcr_rts;
    loop_n[IDX_DSR] = ~mcr_dtr;
    loop_n[IDX_RI]  = ~mcr_out1;
    loop_n[IDX_DCD] = ~mcr_out2;
  end

  assign line_n = loop_en ? loop_n : ext_n;
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import uart_msr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t line_n,
  input  logic      rd_en,
  output line_vec_t prev_n,
  output line_vec_t flags
);
  line_vec_t hit;
  line_vec_t flags_nx;
  logic      flags_ce;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
    if (i == IDX_RI) begin : g_trail
      assign hit[i] = line_n[i] & ~prev_n[i];
    end else begin : g_any
      assign hit[i] = line_n[i] ^ prev_n[i];
    end
  end

  always_comb begin
    flags_ce = rd_en | (|hit);
    flags_nx = hit | (flags & {NUM_LINES{~rd_en}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= '1;
    end else begin
      prev_n <= line_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_ce) begin
      flags <= flags_nx;
    end
  end
endmodule

// File: rtl/uart_msr.sv
module uart_msr
  import uart_msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cts_n,
  input  logic               dsr_n,
  input  logic               ri_n,
  input  logic               dcd_n,
  input  logic               loop_en,
  input  logic               mcr_dtr,
  input  logic               mcr_rts,
  input  logic               mcr_out1,
  input  logic               mcr_out2,
  input  logic               rd_en,
  input  logic               msi_en,
  output logic [RDATA_W-1:0] rdata,
  output logic               irq
);
  line_vec_t pins_n;
  line_vec_t sync_n;
  line_vec_t line_n;
  line_vec_t prev_line_n;
  line_vec_t delta;

  always_comb begin
    pins_n          = '1;
    pins_n[IDX_CTS] = cts_n;
    pins_n[IDX_DSR] = dsr_n;
    pins_n[IDX_RI]  = ri_n;
    pins_n[IDX_DCD] = dcd_n;
  end

  msr_sync #(
    .STAGES  (SYNC_STAGES),
    .WIDTH   (NUM_LINES),
    .RST_VAL ({NUM_LINES{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_n),
    .q     (sync_n)
  );

  msr_src_sel u_sel (
    .loop_en  (loop_en),
    .ext_n    (sync_n),
    .mcr_dtr  (mcr_dtr),
    .mcr_rts  (mcr_rts),
    .mcr_out1 (mcr_out1),
    .mcr_out2 (mcr_out2),
    .line_n   (line_n)
  );

  msr_delta u_delta (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_n (line_n),
    .rd_en  (rd_en),
    .prev_n (prev_line_n),
    .flags  (delta)
  );

  assign rdata = {~line_n, delta};
  assign irq   = msi_en & (|delta);
endmodule

// File: rtl/uart_msr_chk.sv
module uart_msr_chk
  import uart_msr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               loop_en,
  input logic               mcr_dtr,
  input logic               mcr_rts,
  input logic               mcr_out1,
  input logic               mcr_out2,
  input logic               rd_en,
  input logic               msi_en,
  input logic [RDATA_W-1:0] rdata,
  input logic               irq,
  input line_vec_t          line_n,
  input line_vec_t          prev_n
);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && line_n == prev_n) |=> rdata[NUM_LINES-1:0] == '0);

  a_r5_cts_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (line_n[IDX_CTS] != prev_n[IDX_CTS]) |=> rdata[IDX_CTS]);

  a_r2_dcd_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (line_n[IDX_DCD] != prev_n[IDX_DCD]) |=> rdata[IDX_DCD]);

  a_r2_dsr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[IDX_DSR] && !rd_en) |=> rdata[IDX_DSR]);

  a_r3_ring_trailing_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[IDX_RI]) |-> $past(line_n[IDX_RI] && !prev_n[IDX_RI]));

  a_r7_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> rdata[RDATA_W-1:NUM_LINES] == {mcr_out2, mcr_out1, mcr_dtr, mcr_rts});

  a_r9_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && rdata[NUM_LINES-1:0] != '0) |-> irq);

  a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en || rdata[NUM_LINES-1:0] == '0) |-> !irq);
endmodule

bind uart_msr uart_msr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .loop_en  (loop_en),
  .mcr_dtr  (mcr_dtr),
  .mcr_rts  (mcr_rts),
  .mcr_out1 (mcr_out1),
  .mcr_out2 (mcr_out2),
  .rd_en    (rd_en),
  .msi_en   (msi_en),
  .rdata    (rdata),
  .irq      (irq),
  .line_n   (line_n),
  .prev_n   (prev_line_n)
);

// File: tb/tb_uart_msr.sv
module tb_uart_msr;
  logic       clk;
  logic       rst_n;
  logic       cts_n, dsr_n, ri_n, dcd_n;
  logic       loop_en;
  logic       mcr_dtr, mcr_rts, mcr_out1, mcr_out2;
  logic       rd_en, msi_en;
  logic [7:0] rdata;
  logic       irq;

  int n_checks;
  int n_fails;
  int cycles;

  uart_msr dut (
    .clk(clk), .rst_n(rst_n),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .loop_en(loop_en),
    .mcr_dtr(mcr_dtr), .mcr_rts(mcr_rts), .mcr_out1(mcr_out1), .mcr_out2(mcr_out2),
    .rd_en(rd_en), .msi_en(msi_en), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {loop, mcr[3:0]=out2,out1,rts,dtr, pins[3:0]=dcd,ri,dsr,cts, expected rdata}
  localparam logic [16:0] VECS [0:11] = '{
    {1'b0, 4'b0000, 4'b1110, 8'h11},  // R2 cts falls
    {1'b0, 4'b0000, 4'b1100, 8'h32},  // R2 dsr falls
    {1'b0, 4'b0000, 4'b1000, 8'h70},  // R3 ri falls: no flag
    {1'b0, 4'b0000, 4'b1100, 8'h34},  // R3 ri rises: flag
    {1'b0, 4'b0000, 4'b0100, 8'hB8},  // R2 dcd falls
    {1'b0, 4'b0000, 4'b1111, 8'h0B},  // R2 rising edges
    {1'b1, 4'b0000, 4'b0000, 8'h00},  // R7 pins ignored
    {1'b1, 4'b0010, 4'b0000, 8'h11},  // R8 rts
    {1'b1, 4'b0011, 4'b0000, 8'h32},  // R8 dtr
    {1'b1, 4'b1111, 4'b0000, 8'hF8},  // R8 out1 set, out2 set
    {1'b1, 4'b1011, 4'b0000, 8'hB4},  // R8 out1 cleared: ring flag
    {1'b0, 4'b1011, 4'b1111, 8'h0F}   // R1 back to pins
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fails = 0; cycles = 0;
    rst_n = 1'b0;
    {cts_n, dsr_n, ri_n, dcd_n} = 4'b1111;
    {loop_en, mcr_dtr, mcr_rts, mcr_out1, mcr_out2} = '0;
    rd_en = 1'b0; msi_en = 1'b0;
    tick(); tick();
    check("R6 reset state", rdata, 8'h00);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R6 idle after reset", rdata, 8'h00);
    check("R9 irq idle", {7'b0, irq}, 8'h00);

    for (int v = 0; v < 12; v++) begin
      loop_en = VECS[v][16];
      {mcr_out2, mcr_out1, mcr_rts, mcr_dtr} = VECS[v][15:12];
      {dcd_n, ri_n, dsr_n, cts_n} = VECS[v][11:8];
      tick(); tick(); tick();
      check($sformatf("R1/R2/R3/R7/R8 vector %0d", v), rdata, VECS[v][7:0]);
      do_read();
      check($sformatf("R4 clear after vector %0d", v), {4'b0, rdata[3:0]}, 8'h00);
    end

    // R1 synchronizer latency, R5 read meets change
    cts_n = 1'b0;
    tick();
    check("R1 one edge: not yet visible", {7'b0, rdata[4]}, 8'h00);
    tick();
    check("R1 two edges: visible", {7'b0, rdata[4]}, 8'h01);
    do_read();
    check("R5 change wins over read", {7'b0, rdata[0]}, 8'h01);
    tick(); tick(); tick(); tick(); tick();
    check("R2 flag sticky", {7'b0, rdata[0]}, 8'h01);
    msi_en = 1'b1;
    tick();
    check("R9 irq with flag", {7'b0, irq}, 8'h01);
    msi_en = 1'b0;
    tick();
    check("R9 irq gated", {7'b0, irq}, 8'h00);
    msi_en = 1'b1;
    do_read();
    check("R4 read clears", rdata, 8'h10);
    check("R9 irq drops", {7'b0, irq}, 8'h00);

    // R6 lines asserted across reset
    cts_n = 1'b1; dsr_n = 1'b0; dcd_n = 1'b0;
    rst_n = 1'b0;
    tick(); tick();
    check("R6 data during reset", rdata, 8'h00);
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R6 flags set after release", rdata, 8'hAA);
    check("R9 irq after release", {7'b0, irq}, 8'h01);
    do_read();
    check("R4 clear after release", rdata, 8'hA0);

    finish_run();
  end
endmodule